// File: doc/BRIEF.md
# Transport Stream PID Filter

This block screens a transport stream that arrives one byte per valid cycle, with a start-of-packet strobe on the first byte of each 188-byte packet. From the second and third header bytes it assembles the 13-bit packet identifier (PID). Once the third byte is in, it decides whether the whole packet passes or is dropped. Passed packets leave the block unchanged, three register stages later, together with a tag that names the comparator that accepted them.

The decision draws on several comparators. Six single-purpose comparators (two general streams, PCR, PMT, EMM and ECM) each have their own PID register and enable. A group comparator tests the PID under a 13-bit mask. A bank of 32 general slots is reached through an index register and a data register. A global receive enable gates everything, and a null rule can discard packets carrying the null PID. Software programs the block through a simple write-strobe register port, and every register reads back combinationally.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, `out_valid_o` is 0 and every register reads back as 0.
- R2: While control bit 0 (receive enable) is 0, no packet is passed and `out_valid_o` stays 0.
- R3: Control word at address 0 holds these bits: 1 stream A, 2 stream B, 3 PCR, 4 PMT, 5 EMM, 6 ECM, 7 group, 8 null drop. Role PIDs sit in pairs, with the lower field in bits 12:0 and the upper field in bits 25:13: address 1 holds stream A and B, address 2 holds PCR and PMT, address 3 holds EMM and ECM. A role comparator matches only when its enable bit is set and its PID equals the packet PID.
- R4: The tag encodes the winning comparator: 1 stream A, 2 stream B, 3 PCR, 4 PMT, 5 EMM, 6 ECM, 7 group, 8 slot bank. When several comparators match, the lowest code wins. A passed packet always carries a nonzero tag.
- R5: Address 4 holds the group PID in bits 12:0 and the group mask in bits 25:13. When enabled, the group comparator matches when (PID AND mask) equals (group PID AND mask).
- R6: Address 5 holds the 5-bit slot index in bits 4:0. Address 6 reads and writes the indexed slot, with the PID in bits 12:0 and the slot enable in bit 13.
- R7: A slot whose enable bit is 0 never matches. When several enabled slots match, `slot_o` reports the lowest index.
- R8: With null drop set, a packet whose PID is 0x1FFF is dropped even if another comparator matches it.
- R9: The packet PID is bits 4:0 of byte 1 followed by byte 2, and the upper three bits of byte 1 are ignored. A passed packet is emitted complete: all 188 bytes, in order and unchanged, with `out_sop_o` on the first byte only.
- R10: A packet whose first byte is not 0x47 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Input stream byte |
| valid_i | input | 1 | Input byte valid |
| sop_i | input | 1 | First byte of a packet |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 26 | Register write data |
| reg_rdata_o | output | 26 | Register read data for `reg_addr_i` |
| out_byte_o | output | 8 | Passed stream byte |
| out_valid_o | output | 1 | Passed byte valid |
| out_sop_o | output | 1 | First byte of a passed packet |
| tag_o | output | 4 | Winning comparator of the current packet |
| slot_o | output | 5 | Winning slot index when the tag is 8 |

## Verification
The assertions rely on three properties of the input. Bytes 0 to 2 of every packet arrive on consecutive valid cycles. A new start strobe comes only after the previous packet's 188th byte. Registers are not rewritten while a packet is in flight. The bench keeps to all three: it drives each header without gaps and leaves idle cycles between packets, and it reprograms the registers only between packets. Idle gaps are inserted at random only in the payload, after byte 2. This exercises the tail draining through the delay stages.

// File: rtl/ts_pid_pkg.sv
package ts_pid_pkg;
  localparam int PID_W  = 13;
  localparam int DATA_W = 2 * PID_W;
  localparam int ROLE_N = 8;

  typedef logic [PID_W-1:0] pid_t;

  localparam pid_t       NULL_PID  = 13'h1fff;
  localparam logic [7:0] SYNC_BYTE = 8'h47;

  // role register indexes
  localparam int RI_STRM_A = 0;
  localparam int RI_STRM_B = 1;
  localparam int RI_PCR    = 2;
  localparam int RI_PMT    = 3;
  localparam int RI_EMM    = 4;
  localparam int RI_ECM    = 5;
  localparam int RI_GRP    = 6;
  localparam int RI_MASK   = 7;

  typedef enum logic [3:0] {
    TAG_NONE   = 4'd0,
    TAG_STRM_A = 4'd1,
    TAG_STRM_B = 4'd2,
    TAG_PCR    = 4'd3,
    TAG_PMT    = 4'd4,
    TAG_EMM    = 4'd5,
    TAG_ECM    = 4'd6,
    TAG_GRP    = 4'd7,
    TAG_SLOT   = 4'd8
  } tag_e;

  // bit 0 is rx_en
  typedef struct packed {
    logic null_drop;
    logic grp_en;
    logic ecm_en;
    logic emm_en;
    logic pmt_en;
    logic pcr_en;
    logic strm_b_en;
    logic strm_a_en;
    logic rx_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ts_pid_regs.sv
module ts_pid_regs
  import ts_pid_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [2:0]                     addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output ctrl_t                          ctrl_o,
  output logic [ROLE_N-1:0][PID_W-1:0]   role_o,
  output logic [NUM_SLOTS-1:0][PID_W-1:0] slot_pid_o,
  output logic [NUM_SLOTS-1:0]           slot_en_o
);
  localparam int PAIR_N = ROLE_N / 2;

  ctrl_t                            ctrl_q;
  logic [IDX_W-1:0]                 idx_q;
  logic [ROLE_N-1:0][PID_W-1:0]     role_q;
  logic [NUM_SLOTS-1:0][PID_W-1:0]  slot_pid_q;
  logic [NUM_SLOTS-1:0]             slot_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      idx_q  <= '0;
    end else if (we_i) begin
      if (addr_i == 3'd0) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr_i == 3'd5) idx_q  <= wdata_i[IDX_W-1:0];
    end
  end

  // role pairs live at addresses 1..PAIR_N
  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        role_q[2*p]   <= '0;
        role_q[2*p+1] <= '0;
      end else if (we_i && addr_i == 3'(p + 1)) begin
        role_q[2*p]   <= wdata_i[PID_W-1:0];
        role_q[2*p+1] <= wdata_i[DATA_W-1:PID_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_pid_q <= '0;
      slot_en_q  <= '0;
    end else if (we_i && addr_i == 3'd6) begin
      slot_pid_q[idx_q] <= wdata_i[PID_W-1:0];
      slot_en_q[idx_q]  <= wdata_i[PID_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      3'd0:    rdata_o = DATA_W'(ctrl_q);
      3'd1:    rdata_o = {role_q[RI_STRM_B], role_q[RI_STRM_A]};
      3'd2:    rdata_o = {role_q[RI_PMT], role_q[RI_PCR]};
      3'd3:    rdata_o = {role_q[RI_ECM], role_q[RI_EMM]};
      3'd4:    rdata_o = {role_q[RI_MASK], role_q[RI_GRP]};
      3'd5:    rdata_o = DATA_W'(idx_q);
      3'd6:    rdata_o = DATA_W'({slot_en_q[idx_q], slot_pid_q[idx_q]});
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign role_o     = role_q;
  assign slot_pid_o = slot_pid_q;
  assign slot_en_o  = slot_en_q;
endmodule

// File: rtl/ts_pid_match.sv
module ts_pid_match
  import ts_pid_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  pid_t                            pid_i,
  input  ctrl_t                           ctrl_i,
  input  logic [ROLE_N-1:0][PID_W-1:0]    role_i,
  input  logic [NUM_SLOTS-1:0][PID_W-1:0] slot_pid_i,
  input  logic [NUM_SLOTS-1:0]            slot_en_i,
  output tag_e                            tag_o,
  output logic [IDX_W-1:0]                slot_o
);
  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 any_slot;
  logic                 grp_hit;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_hit[i] = slot_en_i[i] && (slot_pid_i[i] == pid_i);
  end

  // lowest index wins
  always_comb begin
    slot_o   = '0;
    any_slot = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slot_hit[i]) begin
        slot_o   = IDX_W'(i);
        any_slot = 1'b1;
      end
    end
  end

  assign grp_hit = ((pid_i ^ role_i[RI_GRP]) & role_i[RI_MASK]) == '0;

  always_comb begin
    if (!ctrl_i.rx_en || (ctrl_i.null_drop && pid_i == NULL_PID)) tag_o = TAG_NONE;
    else if (ctrl_i.strm_a_en && pid_i == role_i[RI_STRM_A])      tag_o = TAG_STRM_A;
    else if (ctrl_i.strm_b_en && pid_i == role_i[RI_STRM_B])      tag_o = TAG_STRM_B;
    else if (ctrl_i.pcr_en    && pid_i == role_i[RI_PCR])         tag_o = TAG_PCR;
    else if (ctrl_i.pmt_en    && pid_i == role_i[RI_PMT])         tag_o = TAG_PMT;
    else if (ctrl_i.emm_en    && pid_i == role_i[RI_EMM])         tag_o = TAG_EMM;
    else if (ctrl_i.ecm_en    && pid_i == role_i[RI_ECM])         tag_o = TAG_ECM;
    else if (ctrl_i.grp_en    && grp_hit)                         tag_o = TAG_GRP;
    else if (any_slot)                                            tag_o = TAG_SLOT;
    else                                                          tag_o = TAG_NONE;
  end
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import ts_pid_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int PKT_LEN   = 188,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int CNT_W = $clog2(PKT_LEN + 1),
  localparam int HDR_N = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [7:0]        out_byte_o,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic [3:0]        tag_o,
  output logic [IDX_W-1:0]  slot_o
);
  ctrl_t                            ctrl;
  logic [ROLE_N-1:0][PID_W-1:0]     role;
  logic [NUM_SLOTS-1:0][PID_W-1:0]  slot_pid;
  logic [NUM_SLOTS-1:0]             slot_en;

  ts_pid_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .ctrl_o(ctrl), .role_o(role), .slot_pid_o(slot_pid), .slot_en_o(slot_en)
  );

  // byte position tracking; idx_q = PKT_LEN means idle
  logic [CNT_W-1:0] idx_q, cur_idx;
  logic             in_pkt, decide;
  logic             sync_ok_q;
  logic [4:0]       pid_hi_q;
  pid_t             dec_pid;

  assign cur_idx = sop_i ? '0 : idx_q;
  assign in_pkt  = valid_i && (cur_idx < CNT_W'(PKT_LEN));
  assign decide  = in_pkt && (cur_idx == CNT_W'(2));
  assign dec_pid = {pid_hi_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= CNT_W'(PKT_LEN);
      sync_ok_q <= 1'b0;
      pid_hi_q  <= '0;
    end else if (in_pkt) begin
      idx_q <= cur_idx + 1'b1;
      if (cur_idx == '0)         sync_ok_q <= (byte_i == SYNC_BYTE);
      if (cur_idx == CNT_W'(1))  pid_hi_q  <= byte_i[4:0];
    end
  end

  tag_e             m_tag;
  logic [IDX_W-1:0] m_slot;

  ts_pid_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .pid_i(dec_pid), .ctrl_i(ctrl), .role_i(role),
    .slot_pid_i(slot_pid), .slot_en_i(slot_en),
    .tag_o(m_tag), .slot_o(m_slot)
  );

  logic             pass_q;
  tag_e             tag_q;
  logic [IDX_W-1:0] slot_q;
  pid_t             pid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q <= 1'b0;
      tag_q  <= TAG_NONE;
      slot_q <= '0;
      pid_q  <= '0;
    end else if (decide) begin
      pass_q <= sync_ok_q && (m_tag != TAG_NONE);
      tag_q  <= sync_ok_q ? m_tag : TAG_NONE;
      slot_q <= m_slot;
      pid_q  <= dec_pid;
    end
  end

  // header delay line: byte 0 leaves it just as the verdict lands
  logic [HDR_N-1:0][7:0] dly_byte;
  logic [HDR_N-1:0]      dly_v, dly_sop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_byte <= '0;
      dly_v    <= '0;
      dly_sop  <= '0;
    end else begin
      dly_byte[0] <= byte_i;
      dly_v[0]    <= in_pkt;
      dly_sop[0]  <= in_pkt && cur_idx == '0;
      for (int s = 1; s < HDR_N; s++) begin
        dly_byte[s] <= dly_byte[s-1];
        dly_v[s]    <= dly_v[s-1];
        dly_sop[s]  <= dly_sop[s-1];
      end
    end
  end

  assign out_valid_o = dly_v[HDR_N-1] && pass_q && ctrl.rx_en;
  assign out_sop_o   = out_valid_o && dly_sop[HDR_N-1];
  assign out_byte_o  = dly_byte[HDR_N-1];
  assign tag_o       = tag_q;
  assign slot_o      = slot_q;
endmodule

// File: rtl/ts_pid_filter_chk.sv
module ts_pid_filter_chk
  import ts_pid_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       out_valid_o,
  input logic       out_sop_o,
  input logic [7:0] out_byte_o,
  input logic [3:0] tag_o,
  input logic       rx_en,
  input logic       null_drop,
  input logic       decide,
  input pid_t       dec_pid,
  input logic       pass_q
);
  // R2
  rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |-> !out_valid_o);

  // R4
  tag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (tag_o != 4'd0 && tag_o <= 4'd8));

  // R10
  sync_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> (out_valid_o && out_byte_o == SYNC_BYTE));

  // R8
  null_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && null_drop && dec_pid == NULL_PID) |=> !pass_q);
endmodule

bind ts_pid_filter ts_pid_filter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .out_valid_o(out_valid_o), .out_sop_o(out_sop_o), .out_byte_o(out_byte_o),
  .tag_o(tag_o), .rx_en(ctrl.rx_en), .null_drop(ctrl.null_drop),
  .decide(decide), .dec_pid(dec_pid), .pass_q(pass_q)
);

// File: tb/ts_pid_filter_bench.sv
`timescale 1ns/1ps
module ts_pid_filter_bench;
  localparam int NS = 32;
  localparam int PL = 188;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  byte_in = 0;
  logic        valid_in = 0, sop_in = 0;
  logic        we = 0;
  logic [2:0]  addr = 0;
  logic [25:0] wdata = 0;
  logic [25:0] rdata;
  logic [7:0]  ob;
  logic        ov, osop;
  logic [3:0]  otag;
  logic [4:0]  oslot;

  ts_pid_filter u_ts_pid_filter (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_in), .valid_i(valid_in), .sop_i(sop_in),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .out_byte_o(ob), .out_valid_o(ov), .out_sop_o(osop), .tag_o(otag), .slot_o(oslot)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // shadow of programmed state
  logic [8:0]  sh_ctrl = 0;
  logic [12:0] sh_role [8];
  logic [12:0] sh_spid [NS];
  logic        sh_sen  [NS];
  int          sh_idx = 0;

  // monitor
  int m_cnt, m_sops, m_bad, m_tag, m_slot;
  logic [12:0] cur_pid;
  int          cur_seed;

  function automatic logic [7:0] pkt_byte(input logic [12:0] pid, input int seed, input int k);
    if (k == 0) return 8'h47;
    if (k == 1) return {3'b101, pid[12:8]};
    if (k == 2) return pid[7:0];
    return 8'((k * 7 + seed) & 255);
  endfunction

  always @(posedge clk) begin
    #1;
    if (ov) begin
      if (osop) begin m_tag = otag; m_slot = oslot; m_sops++; end
      if (ob != pkt_byte(cur_pid, cur_seed, m_cnt)) m_bad++;
      m_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [25:0] d);
    @(negedge clk);
    we = 1; addr = 3'(a); wdata = d;
    @(negedge clk);
    we = 0;
    case (a)
      0: sh_ctrl = d[8:0];
      1, 2, 3, 4: begin sh_role[2*(a-1)] = d[12:0]; sh_role[2*(a-1)+1] = d[25:13]; end
      5: sh_idx = int'(d[4:0]);
      6: begin sh_spid[sh_idx] = d[12:0]; sh_sen[sh_idx] = d[13]; end
      default: ;
    endcase
  endtask

  task automatic set_role(input int r, input logic [12:0] pid);
    logic [12:0] lo, hi;
    lo = (r % 2 == 0) ? pid : sh_role[r-1];
    hi = (r % 2 == 1) ? pid : sh_role[r+1];
    wr(r / 2 + 1, {hi, lo});
  endtask

  task automatic set_slot(input int i, input logic [12:0] pid, input bit en);
    wr(5, 26'(i));
    wr(6, {12'b0, en, pid});
  endtask

  task automatic rd(input int a, input logic [25:0] exp, input string req);
    @(negedge clk);
    addr = 3'(a);
    #1;
    check(rdata == exp, req, int'(rdata), int'(exp));
  endtask

  function automatic int model(input logic [12:0] pid, output int slot);
    slot = 0;
    if (!sh_ctrl[0]) return 0;
    if (sh_ctrl[8] && pid == 13'h1fff) return 0;
    for (int r = 0; r < 6; r++)
      if (sh_ctrl[r+1] && pid == sh_role[r]) return r + 1;
    if (sh_ctrl[7] && ((pid & sh_role[7]) == (sh_role[6] & sh_role[7]))) return 7;
    for (int i = 0; i < NS; i++)
      if (sh_sen[i] && sh_spid[i] == pid) begin slot = i; return 8; end
    return 0;
  endfunction

  task automatic send(input logic [12:0] pid, input bit good_sync, input bit gaps);
    cur_pid = pid; cur_seed = int'($urandom % 256);
    m_cnt = 0; m_sops = 0; m_bad = 0; m_tag = -1; m_slot = -1;
    for (int k = 0; k < PL; k++) begin
      if (gaps && k >= 3 && ($urandom % 4 == 0)) begin
        @(negedge clk); valid_in = 0; sop_in = 0;
      end
      @(negedge clk);
      valid_in = 1; sop_in = (k == 0);
      byte_in = (k == 0 && !good_sync) ? 8'h46 : pkt_byte(pid, cur_seed, k);
    end
    @(negedge clk); valid_in = 0; sop_in = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_pkt(input logic [12:0] pid, input bit good_sync, input string req);
    int et, es;
    et = model(pid, es);
    if (!good_sync) et = 0;
    send(pid, good_sync, 1);
    if (et == 0) check(m_cnt == 0, req, m_cnt, 0);
    else begin
      check(m_cnt == PL && m_sops == 1 && m_bad == 0, {req, " R9 stream"}, m_cnt * 1000 + m_bad, PL * 1000);
      check(m_tag == et, {req, " R4 tag"}, m_tag, et);
      if (et == 8) check(m_slot == es, {req, " R7 slot"}, m_slot, es);
    end
  endtask

  initial begin
    int seed;
    logic [12:0] pool [8];
    seed = $urandom(32'h5eed);
    for (int i = 0; i < 8; i++) sh_role[i] = 0;
    for (int i = 0; i < NS; i++) begin sh_spid[i] = 0; sh_sen[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(ov == 0, "R1 out_valid", ov, 0);
    rd(0, 0, "R1 ctrl");
    rd(6, 0, "R1 slot");

    // R2: comparator set up but receive disabled
    set_role(0, 13'h0100);
    wr(0, 26'h002);
    expect_pkt(13'h0100, 1, "R2 rx off");

    // R3
    wr(0, 26'h003);
    rd(0, 26'h003, "R3 ctrl read");
    rd(1, {13'h0, 13'h0100}, "R3 pair read");
    expect_pkt(13'h0100, 1, "R3 stream A");
    wr(0, 26'h001);
    expect_pkt(13'h0100, 1, "R3 disabled role");

    // R4 priority: pcr, group and slot all match 0x200
    set_role(2, 13'h0200);
    set_role(6, 13'h0200); set_role(7, 13'h1fff);
    set_slot(3, 13'h0200, 1);
    wr(0, 26'h089);
    expect_pkt(13'h0200, 1, "R4 priority");

    // R5 group
    set_role(6, 13'h1230); set_role(7, 13'h1ff0);
    expect_pkt(13'h1234, 1, "R5 group hit");
    expect_pkt(13'h1334, 1, "R5 group miss");

    // R6 / R7 slots
    set_slot(5, 13'h0abc, 1);
    rd(6, {12'b0, 1'b1, 13'h0abc}, "R6 slot read");
    rd(5, 26'd5, "R6 index read");
    set_slot(9, 13'h0abc, 1);
    expect_pkt(13'h0abc, 1, "R7 lowest slot");
    set_slot(5, 13'h0abc, 0);
    expect_pkt(13'h0abc, 1, "R7 disabled slot");
    set_slot(9, 13'h0abc, 0);
    expect_pkt(13'h0abc, 1, "R7 all disabled");

    // R8 null
    set_slot(0, 13'h1fff, 1);
    expect_pkt(13'h1fff, 1, "R8 null pass");
    wr(0, 26'h189);
    expect_pkt(13'h1fff, 1, "R8 null drop");

    // R10 sync
    expect_pkt(13'h0200, 0, "R10 bad sync");

    // random phase
    pool[0] = 13'h0100; pool[1] = 13'h0200; pool[2] = 13'h1fff; pool[3] = 13'h1234;
    for (int r = 0; r < 6; r++) set_role(r, 13'($urandom));
    for (int s = 0; s < 8; s++) set_slot(s * 4 + 1, 13'($urandom), 1'($urandom));
    for (int it = 0; it < 30; it++) begin
      logic [12:0] p;
      if (it % 5 == 0) wr(0, {17'b0, 8'($urandom), 1'b1});
      pool[4] = sh_role[$urandom % 6];
      pool[5] = sh_spid[($urandom % 8) * 4 + 1];
      pool[6] = sh_role[6] ^ 13'($urandom % 16);
      pool[7] = 13'($urandom);
      p = pool[$urandom % 8];
      expect_pkt(p, 1, "R3 R5 R7 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule